// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block derives the bit timing for a serial transceiver from the system clock. A reload value, written one byte at a time through a small write port, sets a base divider that counts the clock and fires once every (value + 1) cycles. A post-multiplier then stretches that base rate by a factor of 4, 16 or 64. The factor is chosen by three controls: synchronous operation, a high-speed select and a wide-reload select.

Two pulses leave the block. The bit tick marks each bit period. The oversample tick is a finer pulse for the receiver's sampling logic, and every bit tick also carries an oversample tick. Writing a reload byte restarts the timing at once, so a new rate takes effect without first running out a period at the old rate. While the port enable is low the block stays idle and silent.

Top module: `ser_rate_gen`

## Requirements
- R1: With reload value n and multiplier M, the bit tick repeats every M*(n+1) clock cycles.
- R2: The reload value is 16 bits. The high byte is written with wr_sel=1 and the low byte with wr_sel=0. When wide_mode is 0, the high byte is ignored and n equals the low byte.
- R3: With sync_mode=1, M is 4 for every setting of hi_speed and wide_mode.
- R4: With sync_mode=0, hi_speed=1 and wide_mode=1, M is 4.
- R5: With sync_mode=0 and exactly one of hi_speed or wide_mode at 1, M is 16.
- R6: With sync_mode=0, hi_speed=0 and wide_mode=0, M is 64.
- R7: A write to either reload byte restarts both the divider and the multiplier. The first bit tick after the write edge appears in the (M*(n+1))-th cycle, and no bit tick appears in the cycle directly after the write. A tick that was already due in the cycle of the write is still issued.
- R8: The bit tick is a one-cycle pulse, and every bit tick coincides with an oversample tick. Between two bit ticks, counting the second one, there are 16 oversample ticks when M is 16 or 64, and 4 when M is 4.
- R9: While port_en is 0, neither tick fires and the timing is held at its start. When port_en rises, the first bit tick appears in the (M*(n+1))-th cycle, counting the first enabled cycle.
- R10: A synchronous active-high reset clears the reload value to 0 and the timing state. Both ticks are 0 while reset is held with port_en at 0. After release with port_en=1 and all mode controls at 0, the first bit tick comes in the 64th cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial port enable; low holds the timing idle |
| sync_mode | input | 1 | Synchronous operation select |
| hi_speed | input | 1 | High-speed select |
| wide_mode | input | 1 | Use the full 16-bit reload value |
| wr_en | input | 1 | Reload byte write strobe |
| wr_sel | input | 1 | Byte select: 1 high byte, 0 low byte |
| wr_data | input | 8 | Reload byte data |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| os_tick | output | 1 | Oversample pulse for receiver sampling |

## Verification
The case of interest is a reload write that lands in the very cycle in which a bit tick is due. The bench provokes it by timing the write strobe to the last cycle of a running period, counted from the previous restart. It then checks three things: the due tick is still visible in that cycle, the cycle after the write carries no tick, and the next tick arrives exactly one new period after the write edge. A second overlap, port enable rising on a held divider, is judged by the position of the first tick after release.

// File: rtl/ser_rate_pkg.sv
package ser_rate_pkg;

    localparam int PRE_W = 6;

    typedef enum logic [1:0] {
        MUL_X4  = 2'd0,
        MUL_X16 = 2'd1,
        MUL_X64 = 2'd2
    } mult_e;

    typedef struct packed {
        logic sync_md;
        logic fast;
        logic wide;
    } mode_t;

    function automatic mult_e pick_mult(input mode_t m);
        mult_e r;
        if (m.sync_md) begin
            r = MUL_X4;
        end else begin
            unique case ({m.fast, m.wide})
                2'b11:        r = MUL_X4;
                2'b10, 2'b01: r = MUL_X16;
                default:      r = MUL_X64;
            endcase
        end
        return r;
    endfunction

    function automatic int mult_value(input mult_e m);
        int v;
        unique case (m)
            MUL_X4:  v = 4;
            MUL_X16: v = 16;
            default: v = 64;
        endcase
        return v;
    endfunction

    function automatic logic [PRE_W-1:0] mult_last(input mult_e m);
        return PRE_W'(mult_value(m) - 1);
    endfunction

    function automatic logic [PRE_W-1:0] os_mask(input mult_e m, input int os_rate);
        int step;
        step = (mult_value(m) > os_rate) ? (mult_value(m) / os_rate) : 1;
        return PRE_W'(step - 1);
    endfunction

endpackage

// File: rtl/ser_rate_regs.sv
module ser_rate_regs #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  wide,
    output logic [2*BYTE_W-1:0]   reload_next
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_q, hi_q;
    logic [BYTE_W-1:0] lo_n, hi_n;

    always_comb begin
        lo_n = (wr_en && !wr_sel) ? wr_data : lo_q;
        hi_n = (wr_en &&  wr_sel) ? wr_data : hi_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    // value the divider loads: write data is visible in the cycle of the write
    assign reload_next = wide ? {hi_n, lo_n} : CNT_W'(lo_n);

endmodule

// File: rtl/ser_rate_div.sv
module ser_rate_div #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    output logic             base_tick
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero   = (cnt_q == '0);
    assign base_tick = run && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run || restart || at_zero) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/ser_rate_post.sv
module ser_rate_post
    import ser_rate_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  restart,
    input  logic  base_tick,
    input  mult_e mult,
    output logic  bit_tick,
    output logic  os_tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;
    logic [PRE_W-1:0] mask;
    logic             at_end;

    always_comb begin
        last   = mult_last(mult);
        mask   = os_mask(mult, OS_RATE);
        at_end = (pre_q >= last);
    end

    assign bit_tick = base_tick && at_end;
    assign os_tick  = base_tick && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_q <= '0;
        end else if (base_tick) begin
            pre_q <= at_end ? '0 : pre_q + 1'b1;
        end
    end

    // R8: a bit tick always carries an oversample tick
    p_bit_has_os_r8: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> os_tick);

    // R8: the bit tick never lasts two cycles
    p_bit_single_r8: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);

endmodule

// File: rtl/ser_rate_gen.sv
module ser_rate_gen
    import ser_rate_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              hi_speed,
    input  logic              wide_mode,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              bit_tick,
    output logic              os_tick
);
    localparam int CNT_W = 2 * BYTE_W;

    mode_t            mode_now, mode_q;
    mult_e            mult;
    logic             mode_chg;
    logic             restart;
    logic             base_tick;
    logic [CNT_W-1:0] reload_next;

    assign mode_now = '{sync_md: sync_mode, fast: hi_speed, wide: wide_mode};
    assign mult     = pick_mult(mode_now);
    assign mode_chg = (mode_now != mode_q);
    assign restart  = wr_en || mode_chg;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_now;
    end

    ser_rate_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .wide        (wide_mode),
        .reload_next (reload_next)
    );

    ser_rate_div #(.CNT_W(CNT_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (port_en),
        .restart   (restart),
        .reload    (reload_next),
        .base_tick (base_tick)
    );

    ser_rate_post #(.OS_RATE(OS_RATE)) u_post (
        .clk       (clk),
        .rst       (rst),
        .run       (port_en),
        .restart   (restart),
        .base_tick (base_tick),
        .mult      (mult),
        .bit_tick  (bit_tick),
        .os_tick   (os_tick)
    );

    // R7: the cycle after a reload write never carries a bit tick
    p_restart_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_en) |=> !bit_tick);

    // R9: the first enabled cycle never carries a bit tick
    p_enable_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(port_en) |-> !bit_tick);

endmodule

// File: tb/ser_rate_gen_bench.sv
module ser_rate_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_en = 1'b0;
    logic       sync_mode = 1'b0;
    logic       hi_speed = 1'b0;
    logic       wide_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bit_tick, os_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ser_rate_gen u_ser_rate_gen (
        .clk(clk), .rst(rst), .port_en(port_en),
        .sync_mode(sync_mode), .hi_speed(hi_speed), .wide_mode(wide_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bit_tick(bit_tick), .os_tick(os_tick)
    );

    // {sync, fast, wide, hi[8], lo[8], period[16], os_per_bit[5]}
    localparam logic [39:0] VEC [0:7] = '{
        {1'b0, 1'b0, 1'b0, 8'd0, 8'd3,  16'd256,  5'd16},  // R6
        {1'b0, 1'b1, 1'b0, 8'd0, 8'd9,  16'd160,  5'd16},  // R5
        {1'b0, 1'b0, 1'b1, 8'd0, 8'd20, 16'd336,  5'd16},  // R5
        {1'b0, 1'b1, 1'b1, 8'd1, 8'd4,  16'd1044, 5'd4},   // R4
        {1'b1, 1'b0, 1'b0, 8'd0, 8'd7,  16'd32,   5'd4},   // R3
        {1'b1, 1'b1, 1'b1, 8'd0, 8'd2,  16'd12,   5'd4},   // R3
        {1'b0, 1'b1, 1'b0, 8'd5, 8'd0,  16'd16,   5'd16},  // R2 high byte ignored
        {1'b1, 1'b0, 1'b1, 8'd2, 8'd0,  16'd2052, 5'd4}    // R2 full width
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    // cycles from now until a bit tick, now counting as 0
    task automatic find_tick(output int k);
        k = 0;
        while (!bit_tick && k < 5000) begin
            @(negedge clk); #1;
            k++;
        end
    endtask

    // from a tick: cycles to the next one and oversample ticks seen on the way
    task automatic next_tick(output int cyc, output int os);
        cyc = 0; os = 0;
        do begin
            @(negedge clk); #1;
            cyc++;
            if (os_tick) os++;
        end while (!bit_tick && cyc < 5000);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int k, cyc, os;
        // R10 reset state
        repeat (4) @(negedge clk);
        #1;
        check(!bit_tick && !os_tick, "R10 ticks low in reset", int'(bit_tick) + int'(os_tick), 0);
        @(negedge clk);
        rst = 1'b0; port_en = 1'b1;
        #1;
        find_tick(k);
        check(k == 63, "R10 first tick after reset", k, 63);

        // table-driven modes and reload values
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            sync_mode = VEC[v][39]; hi_speed = VEC[v][38]; wide_mode = VEC[v][37];
            do_write(1'b1, VEC[v][36:29]);
            do_write(1'b0, VEC[v][28:21]);
            find_tick(k);
            check(k == int'(VEC[v][20:5]) - 1, $sformatf("R1 R7 vec%0d first tick", v), k, int'(VEC[v][20:5]) - 1);
            next_tick(cyc, os);
            check(cyc == int'(VEC[v][20:5]), $sformatf("R1 vec%0d period", v), cyc, int'(VEC[v][20:5]));
            check(os == int'(VEC[v][4:0]), $sformatf("R8 vec%0d oversample count", v), os, int'(VEC[v][4:0]));
        end

        // R9 enable low holds and silences
        @(negedge clk);
        sync_mode = 1'b1; hi_speed = 1'b0; wide_mode = 1'b0;
        do_write(1'b0, 8'd3);
        @(negedge clk);
        port_en = 1'b0;
        cyc = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); #1;
            if (bit_tick || os_tick) cyc++;
        end
        check(cyc == 0, "R9 ticks while disabled", cyc, 0);
        @(negedge clk);
        port_en = 1'b1;
        #1;
        find_tick(k);
        check(k == 15, "R9 first tick after enable", k, 15);

        // R7 restart mid-period with a shorter value
        do_write(1'b0, 8'd3);
        step(6);
        do_write(1'b0, 8'd1);
        find_tick(k);
        check(k == 7, "R7 restart mid-period", k, 7);

        // R7 R2 high-byte write restarts but is ignored in 8-bit mode
        do_write(1'b0, 8'd3);
        step(5);
        do_write(1'b1, 8'd7);
        find_tick(k);
        check(k == 15, "R7 R2 high-byte write", k, 15);

        // R7 write in the cycle where a tick is due
        do_write(1'b0, 8'd3);
        step(14);
        @(negedge clk); #1;
        check(bit_tick == 1'b1, "R7 due tick kept", int'(bit_tick), 1);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'd5;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check(bit_tick == 1'b0, "R7 no tick after write", int'(bit_tick), 0);
        find_tick(k);
        check(k == 23, "R7 period after coincident write", k, 23);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule